// File: doc/BRIEF.md
# Target Latency Retry Timer

This block watches each data phase of a bus access from the target side. It counts bus clocks until the phase finishes. If the target is too slow, it asks the initiator to let go of the bus. The first data phase of every access gets a long allowance. Each later phase of a burst gets a shorter one. When an allowance runs out, the block raises a stop request and a two-bit reason code. The bus is then free for other initiators while the slow target finishes its work.

A data phase counts as finished on a clock edge where both the add-on ready input and the data-phase-complete input are high. The stop request stays high until the frame input is sampled low. The timer then returns to idle and can accept a new access on the next edge where frame is sampled high.

Top module: `lat_retry_timer`

## Requirements
- R1: Out of reset, and while the timer is idle, `stop_o` is 0 and `stop_reason_o` is 2'b00.
- R2: The edge that first samples `frame_i` high opens the first phase. If that phase finishes on any of the following 16 edges, `stop_o` stays 0.
- R3: If the first phase has not finished by the 16th edge after the opening edge, `stop_o` is 1 after that 16th edge and `stop_reason_o` is 2'b01 (first-phase retry).
- R4: In a burst (`burst_i` and `frame_i` high when a phase finishes), the next phase begins at once. If it finishes within the following 8 edges, `stop_o` stays 0.
- R5: If a later burst phase has not finished by the 8th edge after the previous phase finished, `stop_o` is 1 after that edge and `stop_reason_o` is 2'b10 (later-phase disconnect).
- R6: A phase finishes only on an edge where `rdy_i` and `phase_done_i` are both high. Either one alone does not finish the phase.
- R7: `stop_o` and the reason stay unchanged while `frame_i` is sampled high. They return to 0 and 2'b00 after the first edge that samples `frame_i` low.
- R8: While stop is held, `rdy_i` and `phase_done_i` have no effect on the outputs.
- R9: A phase that finishes without the burst continuation ends the access. If `frame_i` is still high, the timer ignores it and raises no stop until `frame_i` is sampled low.
- R10: After the timer returns to idle, a new access restarts the 16-clock first-phase limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_i | input | 1 | Access in progress (high = asserted) |
| burst_i | input | 1 | Access continues with further data phases |
| rdy_i | input | 1 | Add-on target ready |
| phase_done_i | input | 1 | Initiator side confirms the data phase |
| stop_o | output | 1 | Retry / disconnect request |
| stop_reason_o | output | 2 | 00 none, 01 first-phase retry, 10 later-phase disconnect |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a known value at each sampled edge. They also assume the initiator keeps `frame_i` high until it sees the stop or its last phase ends, because the hold and release checks count on frame staying high. The stimulus changes inputs only on the falling edge and never drops frame in the middle of a phase. It drives the ready pair separately to cover partial handshakes, and it places completions exactly on the last allowed edge and one edge past it.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_STOP   = 2'd2,
    ST_DRAIN  = 2'd3
  } lrt_state_e;

  typedef enum logic [1:0] {
    RSN_NONE  = 2'b00,
    RSN_RETRY = 2'b01,
    RSN_DISC  = 2'b10
  } lrt_reason_e;

endpackage

// File: rtl/lrt_rst_sync.sv
module lrt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lrt_phase_timer.sv
module lrt_phase_timer #(
  parameter int FIRST_LIM = 16,
  parameter int NEXT_LIM  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic load_first_i,
  input  logic tick_i,
  output logic expired_o,
  output logic first_o
);

  localparam int CW = $clog2(FIRST_LIM + 1);
  localparam logic [CW-1:0] FIRST_V = CW'(FIRST_LIM);
  localparam logic [CW-1:0] NEXT_V  = CW'(NEXT_LIM);

  logic [CW-1:0] cnt_d, cnt_q;
  logic          first_d, first_q;
  logic [CW-1:0] limit;

  generate
    if (FIRST_LIM == NEXT_LIM) begin : g_one_limit
      assign limit = FIRST_V;
    end else begin : g_two_limits
      assign limit = first_q ? FIRST_V : NEXT_V;
    end
  endgenerate

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    if (load_i) begin
      cnt_d   = CW'(1);
      first_d = load_first_i;
    end else if (tick_i) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (load_i || tick_i) begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  assign expired_o = (cnt_q == limit);
  assign first_o   = first_q;

  // R3 / R5: the count never passes the allowance of the current phase
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R5: a later phase is never measured against the long limit
  a_r5_next_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !load_first_i) |=> (!first_o && !expired_o));

endmodule

// File: rtl/lrt_phase_ctl.sv
module lrt_phase_ctl
  import lrt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_i,
  input  logic        burst_i,
  input  logic        xfer_i,
  input  logic        expired_i,
  input  logic        first_i,
  output logic        load_o,
  output logic        load_first_o,
  output logic        tick_o,
  output logic        stop_o,
  output logic [1:0]  reason_o
);

  lrt_state_e  state_d, state_q;
  lrt_reason_e reason_d, reason_q;

  always_comb begin
    state_d      = state_q;
    reason_d     = reason_q;
    load_o       = 1'b0;
    load_first_o = 1'b0;
    tick_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_i) begin
          state_d      = ST_ACTIVE;
          load_o       = 1'b1;
          load_first_o = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (xfer_i) begin
          if (burst_i && frame_i) begin
            load_o = 1'b1;
          end else begin
            state_d = frame_i ? ST_DRAIN : ST_IDLE;
          end
        end else if (expired_i) begin
          state_d  = ST_STOP;
          reason_d = first_i ? RSN_RETRY : RSN_DISC;
        end else begin
          tick_o = 1'b1;
        end
      end
      ST_STOP: begin
        if (!frame_i) begin
          state_d  = ST_IDLE;
          reason_d = RSN_NONE;
        end
      end
      ST_DRAIN: begin
        if (!frame_i) state_d = ST_IDLE;
      end
      default: begin
        state_d  = ST_IDLE;
        reason_d = RSN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      reason_q <= RSN_NONE;
    end else begin
      state_q  <= state_d;
      reason_q <= reason_d;
    end
  end

  assign stop_o   = (state_q == ST_STOP);
  assign reason_o = reason_q;

  // R1 / R3 / R5: a reason is reported exactly while stop is raised
  a_r1_reason_matches_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o == (reason_o != RSN_NONE));

  // R7: stop is held while frame is sampled high
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && frame_i) |=> (stop_o && $stable(reason_o)));

  // R7: stop falls only after frame was sampled low
  a_r7_release_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_o) |-> !$past(frame_i));

  // R6: a completing edge never raises stop
  a_r6_no_stop_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_o) |-> !$past(xfer_i));

  // R9: after an ended access with frame high, no stop appears
  a_r9_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |=> !stop_o);

endmodule

// File: rtl/lat_retry_timer.sv
module lat_retry_timer #(
  parameter int FIRST_LIM = 16,
  parameter int NEXT_LIM  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_i,
  input  logic       burst_i,
  input  logic       rdy_i,
  input  logic       phase_done_i,
  output logic       stop_o,
  output logic [1:0] stop_reason_o
);

  logic rst_sync_n;
  logic xfer;
  logic load, load_first, tick, expired, first;

  assign xfer = rdy_i & phase_done_i;

  lrt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lrt_phase_timer #(.FIRST_LIM(FIRST_LIM), .NEXT_LIM(NEXT_LIM)) u_timer (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load_i       (load),
    .load_first_i (load_first),
    .tick_i       (tick),
    .expired_o    (expired),
    .first_o      (first)
  );

  lrt_phase_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .frame_i      (frame_i),
    .burst_i      (burst_i),
    .xfer_i       (xfer),
    .expired_i    (expired),
    .first_i      (first),
    .load_o       (load),
    .load_first_o (load_first),
    .tick_o       (tick),
    .stop_o       (stop_o),
    .reason_o     (stop_reason_o)
  );

  // R8: while stop is held with frame high, handshakes change nothing
  a_r8_ready_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop_o && frame_i && xfer) |=> (stop_o && $stable(stop_reason_o)));

endmodule

// File: tb/lat_retry_timer_bench.sv
`timescale 1ns/1ps
module lat_retry_timer_bench;

  typedef struct {
    logic       stop;
    logic [1:0] rsn;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame, burst, rdy, done;
  logic       stop;
  logic [1:0] rsn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit reported = 0;
  exp_t q[$];

  // reference state, written from the requirements
  int m_mode  = 0;   // 0 idle, 1 active, 2 stop, 3 drain
  int m_el    = 0;
  bit m_first = 0;
  logic [1:0] m_rsn = 2'b00;

  always #2.5 clk = ~clk;

  lat_retry_timer u_lat_retry_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_i       (frame),
    .burst_i       (burst),
    .rdy_i         (rdy),
    .phase_done_i  (done),
    .stop_o        (stop),
    .stop_reason_o (rsn)
  );

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic model(input logic f, b, r, d);
    case (m_mode)
      0: if (f) begin m_mode = 1; m_el = 1; m_first = 1; end
      1: begin
        if (r && d) begin
          if (b && f) begin m_el = 1; m_first = 0; end
          else m_mode = f ? 3 : 0;
        end else if (m_el == (m_first ? 16 : 8)) begin
          m_mode = 2;
          m_rsn  = m_first ? 2'b01 : 2'b10;
        end else m_el++;
      end
      2: if (!f) begin m_mode = 0; m_rsn = 2'b00; end
      default: if (!f) m_mode = 0;
    endcase
  endtask

  task automatic step(input logic f, b, r, d, input string tag);
    exp_t e;
    @(negedge clk);
    frame = f; burst = b; rdy = r; done = d;
    @(posedge clk);
    model(f, b, r, d);
    e.stop = (m_mode == 2);
    e.rsn  = m_rsn;
    e.tag  = tag;
    #1 q.push_back(e);
  endtask

  task automatic wait_n(input int n, input logic b, input string tag);
    for (int i = 0; i < n; i++) step(1, b, 0, 0, tag);
  endtask

  // monitor: compare one expected item per cycle, away from the clock edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (stop !== e.stop || rsn !== e.rsn) begin
        errors++;
        $display("FAIL %s actual stop=%b reason=%b expected stop=%b reason=%b",
                 e.tag, stop, rsn, e.stop, e.rsn);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame = 0; burst = 0; rdy = 0; done = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (stop !== 1'b0 || rsn !== 2'b00) begin
      errors++;
      $display("FAIL R1 in reset actual stop=%b reason=%b expected stop=0 reason=00", stop, rsn);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R1 idle");

    // R2: first phase ends exactly on the 16th edge
    step(1, 0, 0, 0, "R2 open");
    wait_n(15, 0, "R2 wait");
    step(0, 0, 1, 1, "R2 complete at limit");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R2 after");

    // R3: first phase misses the limit; R8 handshakes ignored; R7 hold/release
    step(1, 0, 0, 0, "R3 open");
    wait_n(15, 0, "R3 wait");
    step(1, 0, 0, 0, "R3 retry raised");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, "R8 ready ignored");
    wait_n(2, 0, "R7 hold");
    step(0, 0, 0, 0, "R7 release");
    step(0, 0, 0, 0, "R7 idle");

    // R4: burst phases within 8 edges
    step(1, 1, 0, 0, "R4 open");
    wait_n(4, 1, "R4 first wait");
    step(1, 1, 1, 1, "R4 first done");
    wait_n(7, 1, "R4 later wait");
    step(1, 1, 1, 1, "R4 later done at limit");
    wait_n(7, 1, "R4 last wait");
    step(0, 1, 1, 1, "R4 last done");
    step(0, 0, 0, 0, "R4 idle");

    // R5: later phase overruns
    step(1, 1, 0, 0, "R5 open");
    step(1, 1, 1, 1, "R5 first done");
    wait_n(7, 1, "R5 wait");
    step(1, 1, 0, 0, "R5 disconnect raised");
    wait_n(2, 1, "R5 hold");
    step(0, 0, 0, 0, "R5 release");

    // R6: partial handshakes do not finish the phase
    step(1, 0, 0, 0, "R6 open");
    for (int i = 0; i < 16; i++)
      step(1, 0, (i % 2) == 0, (i % 2) == 1, "R6 partial handshake");
    step(1, 0, 0, 0, "R6 hold");
    step(0, 0, 0, 0, "R6 release");

    // R9: single phase ends with frame still high
    step(1, 0, 0, 0, "R9 open");
    wait_n(2, 0, "R9 wait");
    step(1, 0, 1, 1, "R9 complete frame high");
    wait_n(20, 0, "R9 drain no stop");
    step(0, 0, 0, 0, "R9 frame low");

    // R10: new access restarts the 16-clock limit
    step(1, 0, 0, 0, "R10 open");
    wait_n(14, 0, "R10 wait");
    step(1, 0, 0, 0, "R10 edge 15 no stop");
    step(1, 0, 0, 0, "R10 retry at 16");
    step(0, 0, 0, 0, "R10 release");
    step(0, 0, 0, 0, "R10 idle");

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule